// File: doc/BRIEF.md
# Indirect Memory Window Port

This block gives a host, through eight byte-wide registers, access to a local memory that holds 32-bit words. The host first loads a byte address split over two address registers. The low address register also carries a 2-bit access-type field. The host then reads or writes the four data byte registers. Each data byte register maps onto one byte lane of the memory word that the address selects. When the access type asks for auto-increment, an access to the highest data byte register moves the window to the next word. A host can therefore stream a block of memory without reloading the address.

Two of the eight offsets are mailbox bytes. One is written by the host and seen by local logic. The other is written by local logic and read by the host. The local memory is modelled inside the block. It has 2**RAM_AW words and is indexed by the low bits of the word address, so higher addresses alias onto it.

Top module: `idx_mem_window`

## Requirements
- R1: A host write to offset 0 stores the byte in the host-to-local mailbox. The byte appears on `h2l_mbox` and reads back at offset 0.
- R2: Offset 1 returns the byte that the local side last stored with `loc_mbox_wr`. Host writes to offset 1 leave it unchanged.
- R3: A host write to offset 2 sets the access type from bits [1:0] (0 byte, 1 half-word, 2 word, 3 word with auto-increment) and address bits [7:2] from bits [7:2]. Reading offset 2 returns {address[7:2], type}.
- R4: A host write to offset 3 sets address bits [14:8] from bits [6:0] and discards bit 7. Reading offset 3 returns {0, address[14:8]}.
- R5: When the access type is 3, a read or a write of offset 7 completes at the current word and then advances the word address by one. The address therefore rises by 4 bytes, and it wraps from 0x7FFC to 0.
- R6: A write to offset 4+k changes only bits [8k+7:8k] of the addressed word. A read of offset 4+k returns those bits.
- R7: With access type 0, 1 or 2, no data access changes the address. With type 3, offsets 4 to 6 do not change it.
- R8: A transfer may begin at offset 5, 6 or 7 to reach a byte inside the current word. The address register stays the same until the offset 7 access.
- R9: A new address, or a wrap, applies to the very next data access, with no stale data.
- R10: With `rst_n` low at a clock edge, the address, the access type, both mailboxes and `hb_rdata` all become 0.
- R11: `hb_rdata` is loaded at the clock edge that samples `hb_rd` and holds until the next read. A read that coincides with `hb_wr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_off | input | 3 | Register offset inside the window |
| hb_rd | input | 1 | Read strobe, one cycle per access |
| hb_wr | input | 1 | Write strobe, one cycle per access |
| hb_wdata | input | 8 | Write data |
| hb_rdata | output | 8 | Registered read data |
| loc_mbox_wr | input | 1 | Local strobe that loads the local-to-host mailbox |
| loc_mbox_wdata | input | 8 | Local-to-host mailbox data |
| h2l_mbox | output | 8 | Host-to-local mailbox contents |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a data access at offset 7 in auto-increment mode. At that edge the byte lane is written or read and the address also steps. The bench writes the fourth lane and then reads the address registers and both neighbouring words. This shows that the write landed in the old word and that the next access reaches the new one. The same path is driven at the top address, where the step wraps to zero.

The second pair is a local mailbox update in the same cycle as a host read of offset 1. The bench expects the old byte from that read and the new byte from the following read.

// File: rtl/idxwin_pkg.sv
// Package: shared types for the indirect memory window.
// Holds the register offsets and the access-type encoding that the
// address register and the top-level read mux decode.
package idxwin_pkg;

    localparam int OFF_W  = 3;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef enum logic [OFF_W-1:0] {
        OFF_H2L  = 3'd0,
        OFF_L2H  = 3'd1,
        OFF_ADR0 = 3'd2,
        OFF_ADR1 = 3'd3,
        OFF_DAT0 = 3'd4,
        OFF_DAT1 = 3'd5,
        OFF_DAT2 = 3'd6,
        OFF_DAT3 = 3'd7
    } win_off_e;

    typedef enum logic [1:0] {
        ACC_BYTE     = 2'd0,
        ACC_HALF     = 2'd1,
        ACC_WORD     = 2'd2,
        ACC_WORD_INC = 2'd3
    } acc_mode_e;

endpackage

// File: rtl/idxwin_addr.sv
// Module: address and access-type register of the window.
// Holds a word address (byte address without its two low bits) plus the
// access type. Host writes to the two address bytes load it. A step
// request advances it by one word, but only in auto-increment mode.
// Assumes: the caller never raises a low-byte and a high-byte write in
// the same cycle. ADDR_W is between 9 and 16.
module idxwin_addr
    import idxwin_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step,
    output logic [ADDR_W-3:0] word_addr,
    output acc_mode_e         mode,
    output logic [BYTE_W-1:0] lo_byte,
    output logic [BYTE_W-1:0] hi_byte
);

    localparam int WA_W = ADDR_W - 2;
    localparam int LO_W = BYTE_W - 2;
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [WA_W-1:0] word_q;
    acc_mode_e       mode_q;

    // Load from host bytes, or step by one word in auto-increment mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            mode_q <= ACC_BYTE;
        end else if (wr_lo) begin
            word_q[LO_W-1:0] <= wdata[BYTE_W-1:2];
            mode_q           <= acc_mode_e'(wdata[1:0]);
        end else if (wr_hi) begin
            word_q[WA_W-1:LO_W] <= wdata[HI_W-1:0];
        end else if (step && mode_q == ACC_WORD_INC) begin
            word_q <= word_q + 1'b1;
        end
    end

    // Read-back images of the two address bytes, unused upper bits zero.
    always_comb begin
        lo_byte = {word_q[LO_W-1:0], mode_q};
        hi_byte = '0;
        hi_byte[HI_W-1:0] = word_q[WA_W-1:LO_W];
    end

    assign word_addr = word_q;
    assign mode      = mode_q;

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_lo && !wr_hi && mode_q == ACC_WORD_INC)
        |=> word_q == $past(word_q) + 1'b1); // R5

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi && (!step || mode_q != ACC_WORD_INC))
        |=> $stable(word_q)); // R7

endmodule

// File: rtl/idxwin_lane.sv
// Module: byte-lane steering between the host byte bus and the word port.
// Decodes one byte-enable for each data offset, copies the write byte onto
// every lane, and picks the lane for a read from the low offset bits.
// Assumes: lane k sits at offset 4+k and at word bits [8k+7:8k].
module idxwin_lane
    import idxwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  off,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [WORD_W-1:0] rword,
    output logic [LANES-1:0]  be,
    output logic [WORD_W-1:0] wword,
    output logic [BYTE_W-1:0] lane_rdata
);

    // One enable and one write-data copy for each lane.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign be[k] = wr && (off == 3'(OFF_DAT0 + k));
        assign wword[k*BYTE_W +: BYTE_W] = wdata;
    end

    // Read lane selection from the low offset bits.
    always_comb begin
        lane_rdata = rword[off[1:0]*BYTE_W +: BYTE_W];
    end

    AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(be)); // R6

endmodule

// File: rtl/idxwin_ram.sv
// Module: local word memory model with per-lane write enables.
// Writes are synchronous and reads are combinational, so a new address
// shows up on rword in the same cycle. The contents are not reset.
module idxwin_ram
    import idxwin_pkg::*;
#(
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic [RAM_AW-1:0] idx,
    input  logic [LANES-1:0]  be,
    input  logic [WORD_W-1:0] wword,
    output logic [WORD_W-1:0] rword
);

    localparam int DEPTH = 1 << RAM_AW;

    logic [WORD_W-1:0] mem [DEPTH];

    // Byte-lane writes, one process for each lane.
    for (genvar k = 0; k < LANES; k++) begin : g_wr
        always_ff @(posedge clk) begin
            if (be[k]) mem[idx][k*BYTE_W +: BYTE_W] <= wword[k*BYTE_W +: BYTE_W];
        end
    end

    assign rword = mem[idx];

endmodule

// File: rtl/idx_mem_window.sv
// Module: top of the indirect memory window.
// Decodes the eight host offsets, holds both mailbox bytes and the
// registered read data, and connects the address register, the lane
// steering and the memory model.
// Assumes: one strobe per access. When hb_rd and hb_wr are both high the
// write is performed and the read is dropped. RAM_AW <= ADDR_W-2.
module idx_mem_window
    import idxwin_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  hb_off,
    input  logic              hb_rd,
    input  logic              hb_wr,
    input  logic [BYTE_W-1:0] hb_wdata,
    output logic [BYTE_W-1:0] hb_rdata,
    input  logic              loc_mbox_wr,
    input  logic [BYTE_W-1:0] loc_mbox_wdata,
    output logic [BYTE_W-1:0] h2l_mbox
);

    localparam int WA_W = ADDR_W - 2;

    win_off_e          off_e;
    logic              rd_eff;
    logic              data_acc;
    logic              step;
    logic [WA_W-1:0]   word_addr;
    acc_mode_e         mode;
    logic [BYTE_W-1:0] lo_byte;
    logic [BYTE_W-1:0] hi_byte;
    logic [LANES-1:0]  be;
    logic [WORD_W-1:0] wword;
    logic [WORD_W-1:0] rword;
    logic [BYTE_W-1:0] lane_rdata;
    logic [BYTE_W-1:0] rd_mux;
    logic [BYTE_W-1:0] h2l_q;
    logic [BYTE_W-1:0] l2h_q;
    logic [BYTE_W-1:0] rdata_q;

    assign off_e    = win_off_e'(hb_off);
    assign rd_eff   = hb_rd && !hb_wr;
    assign data_acc = (rd_eff || hb_wr) && hb_off[2];
    assign step     = (rd_eff || hb_wr) && off_e == OFF_DAT3;

    idxwin_addr #(.ADDR_W(ADDR_W)) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (hb_wr && off_e == OFF_ADR0),
        .wr_hi     (hb_wr && off_e == OFF_ADR1),
        .wdata     (hb_wdata),
        .step      (step),
        .word_addr (word_addr),
        .mode      (mode),
        .lo_byte   (lo_byte),
        .hi_byte   (hi_byte)
    );

    idxwin_lane i_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .off        (hb_off),
        .wr         (hb_wr),
        .wdata      (hb_wdata),
        .rword      (rword),
        .be         (be),
        .wword      (wword),
        .lane_rdata (lane_rdata)
    );

    idxwin_ram #(.RAM_AW(RAM_AW)) i_ram (
        .clk   (clk),
        .idx   (word_addr[RAM_AW-1:0]),
        .be    (be),
        .wword (wword),
        .rword (rword)
    );

    // Host-to-local mailbox, written only by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)                            h2l_q <= '0;
        else if (hb_wr && off_e == OFF_H2L)    h2l_q <= hb_wdata;
    end

    // Local-to-host mailbox, written only by the local side.
    always_ff @(posedge clk) begin
        if (!rst_n)           l2h_q <= '0;
        else if (loc_mbox_wr) l2h_q <= loc_mbox_wdata;
    end

    // Read-data source for each offset.
    always_comb begin
        unique case (off_e)
            OFF_H2L:  rd_mux = h2l_q;
            OFF_L2H:  rd_mux = l2h_q;
            OFF_ADR0: rd_mux = lo_byte;
            OFF_ADR1: rd_mux = hi_byte;
            default:  rd_mux = lane_rdata;
        endcase
    end

    // Register the read data on each accepted read and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_eff) rdata_q <= rd_mux;
    end

    assign hb_rdata = rdata_q;
    assign h2l_mbox = h2l_q;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_eff |=> $stable(hb_rdata)); // R11

    AST_ADR1_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_eff && off_e == OFF_ADR1) |=> !hb_rdata[7]); // R4

    AST_L2H_HOST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_wr && off_e == OFF_L2H && !loc_mbox_wr) |=> $stable(l2h_q)); // R2

    AST_H2L_ONLY_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        !(hb_wr && off_e == OFF_H2L) |=> $stable(h2l_mbox)); // R1

    AST_DATA_NO_MBOX: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !loc_mbox_wr) |=> $stable(l2h_q)); // R2

endmodule

// File: tb/test_idx_mem_window.sv
// Bench for idx_mem_window: a vector table walked by one loop, then
// directed tests for reset, the mailboxes and coincident events.
module test_idx_mem_window;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hb_off = '0;
    logic       hb_rd = 1'b0;
    logic       hb_wr = 1'b0;
    logic [7:0] hb_wdata = '0;
    logic [7:0] hb_rdata;
    logic       loc_mbox_wr = 1'b0;
    logic [7:0] loc_mbox_wdata = '0;
    logic [7:0] h2l_mbox;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    idx_mem_window i_idx_mem_window (
        .clk            (clk),
        .rst_n          (rst_n),
        .hb_off         (hb_off),
        .hb_rd          (hb_rd),
        .hb_wr          (hb_wr),
        .hb_wdata       (hb_wdata),
        .hb_rdata       (hb_rdata),
        .loc_mbox_wr    (loc_mbox_wr),
        .loc_mbox_wdata (loc_mbox_wdata),
        .h2l_mbox       (h2l_mbox)
    );

    // Vector: {kind(1: 0 write, 1 read and compare), offset(3), data or expected(8), req(4)}
    localparam int NV = 43;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 3'd2, 8'h03, 4'd3},  // R3 address 0, auto-increment
        {1'b0, 3'd3, 8'h00, 4'd4},  // R4
        {1'b0, 3'd4, 8'h11, 4'd6},  // R6 word 0 lanes
        {1'b0, 3'd5, 8'h22, 4'd6},
        {1'b0, 3'd6, 8'h33, 4'd6},
        {1'b0, 3'd7, 8'h44, 4'd5},  // R5 lane 3 then step to word 1
        {1'b0, 3'd4, 8'h55, 4'd6},
        {1'b0, 3'd5, 8'h66, 4'd6},
        {1'b0, 3'd6, 8'h77, 4'd6},
        {1'b0, 3'd7, 8'h88, 4'd5},
        {1'b1, 3'd2, 8'h0B, 4'd5},  // R5 now at byte 8
        {1'b0, 3'd2, 8'h03, 4'd9},  // R9 back to word 0
        {1'b1, 3'd4, 8'h11, 4'd9},
        {1'b1, 3'd5, 8'h22, 4'd6},
        {1'b1, 3'd6, 8'h33, 4'd6},
        {1'b1, 3'd7, 8'h44, 4'd5},
        {1'b1, 3'd4, 8'h55, 4'd5},  // R5 read stepped to word 1
        {1'b1, 3'd2, 8'h07, 4'd5},
        {1'b0, 3'd2, 8'h02, 4'd7},  // R7 word mode, address 0
        {1'b1, 3'd7, 8'h44, 4'd7},
        {1'b1, 3'd7, 8'h44, 4'd7},
        {1'b1, 3'd2, 8'h02, 4'd7},
        {1'b0, 3'd5, 8'hAB, 4'd6},  // R6 single lane write
        {1'b1, 3'd4, 8'h11, 4'd6},
        {1'b1, 3'd5, 8'hAB, 4'd6},
        {1'b1, 3'd6, 8'h33, 4'd6},
        {1'b0, 3'd2, 8'h01, 4'd7},  // R7 half-word mode
        {1'b0, 3'd7, 8'h99, 4'd7},
        {1'b1, 3'd2, 8'h01, 4'd7},
        {1'b1, 3'd7, 8'h99, 4'd7},
        {1'b0, 3'd3, 8'hFF, 4'd4},  // R4 bit 7 dropped
        {1'b1, 3'd3, 8'h7F, 4'd4},
        {1'b0, 3'd2, 8'hFF, 4'd3},  // R3 top word, auto-increment
        {1'b1, 3'd2, 8'hFF, 4'd3},
        {1'b0, 3'd7, 8'h5A, 4'd5},  // R5 wrap to 0
        {1'b1, 3'd2, 8'h03, 4'd5},
        {1'b1, 3'd3, 8'h00, 4'd5},
        {1'b1, 3'd4, 8'h11, 4'd9},  // R9 wrapped address used at once
        {1'b0, 3'd2, 8'h03, 4'd8},  // R8 misaligned start in lane 2
        {1'b1, 3'd6, 8'h33, 4'd8},
        {1'b1, 3'd2, 8'h03, 4'd8},
        {1'b1, 3'd7, 8'h99, 4'd8},
        {1'b1, 3'd4, 8'h55, 4'd8}
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        hb_off = off; hb_wdata = d; hb_wr = 1'b1;
        @(negedge clk);
        hb_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] off, output logic [7:0] d);
        @(negedge clk);
        hb_off = off; hb_rd = 1'b1;
        @(negedge clk);
        hb_rd = 1'b0;
        d = hb_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check(hb_rdata, 8'h00, 10);
        check(h2l_mbox, 8'h00, 10);
        for (int o = 0; o < 4; o++) begin
            host_rd(3'(o), v);
            check(v, 8'h00, 10);
        end

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][15]) begin
                host_rd(VEC[i][14:12], v);
                check(v, VEC[i][11:4], int'(VEC[i][3:0]));
            end else begin
                host_wr(VEC[i][14:12], VEC[i][11:4]);
            end
        end

        // R1 host-to-local mailbox
        host_wr(3'd0, 8'hC3);
        check(h2l_mbox, 8'hC3, 1);
        host_rd(3'd0, v);
        check(v, 8'hC3, 1);

        // R2 host write to offset 1 has no effect
        host_wr(3'd1, 8'h77);
        host_rd(3'd1, v);
        check(v, 8'h00, 2);

        // R2 local write, then R11 coincident with a host read
        @(negedge clk);
        loc_mbox_wr = 1'b1; loc_mbox_wdata = 8'h3C;
        @(negedge clk);
        loc_mbox_wr = 1'b0;
        host_rd(3'd1, v);
        check(v, 8'h3C, 2);
        @(negedge clk);
        hb_off = 3'd1; hb_rd = 1'b1;
        loc_mbox_wr = 1'b1; loc_mbox_wdata = 8'hE1;
        @(negedge clk);
        hb_rd = 1'b0; loc_mbox_wr = 1'b0;
        check(hb_rdata, 8'h3C, 11);
        host_rd(3'd1, v);
        check(v, 8'hE1, 11);

        // R11 read data holds across writes; read dropped when hb_wr is high
        host_wr(3'd0, 8'h5D);
        check(hb_rdata, 8'hE1, 11);
        @(negedge clk);
        hb_off = 3'd0; hb_rd = 1'b1; hb_wr = 1'b1; hb_wdata = 8'h6E;
        @(negedge clk);
        hb_rd = 1'b0; hb_wr = 1'b0;
        check(hb_rdata, 8'hE1, 11);
        check(h2l_mbox, 8'h6E, 11);

        // R10 reset in mid-run
        host_wr(3'd2, 8'hFE);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(hb_rdata, 8'h00, 10);
        check(h2l_mbox, 8'h00, 10);
        host_rd(3'd2, v);
        check(v, 8'h00, 10);
        host_rd(3'd1, v);
        check(v, 8'h00, 10);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule